// File: doc/BRIEF.md
# ADPCM Pole-Zero Signal Estimator

This block produces the per-sample prediction used by an adaptive differential PCM codec. It keeps two short histories. One holds the last six quantized difference samples and feeds a sixth-order zero section. The other holds the last two reconstructed samples and feeds a second-order pole section. Samples are not stored as full-width integers. Each history entry is kept in a compact floating form: a sign bit, a 4-bit exponent and a 6-bit normalized mantissa. Each of the eight products is formed by a reduced floating multiply against a 16-bit Q14 coefficient.

One computation runs per sample. The codec first pushes the newest difference and reconstructed samples through the push stream. It then presents the coefficient set and raises `start_valid`. The block forms one product per clock. It reports the zero-section estimate first and the full estimate after the last product.

Both input streams use valid/ready handshakes. A transfer happens in a cycle where valid and ready are both high. `start_ready` is low while a computation is running. `push_ready` is low while a computation is running and also in any cycle where `start_valid` is high, so a start always wins over a push in the same cycle. The two outputs cannot be back-pressured. Each result is announced by a one-cycle strobe and then held until it is replaced.

The coefficient inputs are read during the computation cycles. They must stay stable from the accepted start until `se_valid`.

Top module: `adpcm_sig_est`

## Requirements
- R1: After an asynchronous reset, both outputs are 0, both strobes are low, both ready signals are high, and every history entry holds the float form of zero: sign 0, exponent 0, mantissa 32. With all eight coefficients equal to 16384, a computation on this history gives sez = 3 and se = 4.
- R2: A sample is pushed as a 16-bit two's complement value and stored as follows. The sign is bit 15 of the sample. The magnitude is limited to 32767. The exponent is the bit position of the leading one of the magnitude plus one, or 0 for a zero magnitude. The mantissa is the magnitude normalized to six bits, with its top bit set, or 32 for zero.
- R3: Each product is formed in four steps. First, the coefficient magnitude is taken as its absolute value shifted right by 2 and kept to 13 bits. Second, this magnitude is converted to float in the same way as a sample. Third, the exponents are added to give E, and the mantissas are multiplied, 48 is added and the sum is shifted right by 4 to give W. Fourth, the magnitude is (W << (E-19)) kept to 15 bits when E > 19, and W >> (19-E) otherwise. The product is negated when the coefficient sign and the sample sign differ.
- R4: sez is the 16-bit wrapped sum of the six zero-section products, arithmetically shifted right by one. Coefficient b1 sits in coef_b bits 15:0 and pairs with the newest difference sample. Each next coefficient takes the next 16 bits and pairs with the next older sample.
- R5: se is the 16-bit wrapped sum of all eight products, arithmetically shifted right by one. Coefficient a1 sits in coef_a bits 15:0 and pairs with the newest reconstructed sample. Coefficient a2 sits in bits 31:16 and pairs with the older one.
- R6: Take the clock edge that accepts start as edge 0. sez_valid is then high for exactly one cycle after edge 6, and se_valid is high for exactly one cycle after edge 8.
- R7: start_ready is low from the accepted start until se_valid. A start offered in that window is ignored and creates no extra strobe.
- R8: An accepted push shifts both histories by one entry. The new samples enter at the newest entry and the oldest entries are dropped. push_ready is low while busy or while start_valid is high. A push that is not accepted leaves the histories unchanged.
- R9: sez_out and se_out change only in the cycle where their strobe is high. Otherwise they hold their last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_valid | input | 1 | Request to compute one estimate |
| start_ready | output | 1 | High when a start can be accepted (idle) |
| push_valid | input | 1 | Offer of new history samples |
| push_ready | output | 1 | High when a push can be accepted |
| dq_in | input | 16 | Newest quantized difference sample, two's complement |
| sr_in | input | 16 | Newest reconstructed sample, two's complement |
| coef_b | input | 96 | Zero-section coefficients b1..b6, Q14, b1 in the low 16 bits |
| coef_a | input | 32 | Pole-section coefficients a1, a2, Q14, a1 in the low 16 bits |
| sez_out | output | 16 | Zero-section estimate, two's complement |
| sez_valid | output | 1 | One-cycle strobe for a new sez_out |
| se_out | output | 16 | Full signal estimate, two's complement |
| se_valid | output | 1 | One-cycle strobe for a new se_out; marks the end of the computation |

## Verification
A wrong value in a zero-section history entry shows up in both sez_out and se_out at the next computation. It appears six cycles after start, but only when the paired coefficient is nonzero. A wrong pole-section entry shows only in se_out, eight cycles after start. For this reason the bench sweeps coefficient sets that make every tap contribute. A stuck tap counter or a wrong accumulator corrupts both results in the same computation and usually shifts the strobe timing as well. A bad reset image shows at once as a departure from the sez = 3, se = 4 signature obtained with unit coefficients.

// File: rtl/adpcm_est_pkg.sv
package adpcm_est_pkg;

  localparam int EXP_W  = 4;
  localparam int MANT_W = 6;

  // compact float held in each history entry
  typedef struct packed {
    logic              sgn;
    logic [EXP_W-1:0]  ex;
    logic [MANT_W-1:0] mt;
  } fp_t;

  localparam fp_t FP_ZERO = '{sgn: 1'b0, ex: '0, mt: MANT_W'(1 << (MANT_W - 1))};

  // leading-one position plus one, zero for a zero word
  function automatic int unsigned lead_exp(input logic [31:0] v);
    int unsigned e;
    e = 0;
    for (int i = 0; i < 32; i++) begin
      if (v[i]) e = i + 1;
    end
    return e;
  endfunction

  // normalize a magnitude to MANT_W bits with the top bit set
  function automatic logic [MANT_W-1:0] norm_mant(input logic [31:0] mag, input int unsigned e);
    logic [31:0] t;
    if (e == 0)           t = 32'(1 << (MANT_W - 1));
    else if (e >= MANT_W) t = mag >> (e - MANT_W);
    else                  t = mag << (MANT_W - e);
    return t[MANT_W-1:0];
  endfunction

endpackage

// File: rtl/est_fconv.sv
module est_fconv
  import adpcm_est_pkg::*;
#(
  parameter int IN_W = 16
) (
  input  logic signed [IN_W-1:0] smp,
  output fp_t                    fp
);

  localparam int MAG_MAX = (1 << ((1 << EXP_W) - 1)) - 1;

  logic signed [31:0] s_ext;
  logic [31:0]        mag_raw;
  logic [31:0]        mag;
  int unsigned        e;

  always_comb begin
    s_ext   = 32'(smp);
    mag_raw = s_ext[31] ? 32'(-s_ext) : 32'(s_ext);
    mag     = (mag_raw > 32'(MAG_MAX)) ? 32'(MAG_MAX) : mag_raw;
    e       = lead_exp(mag);
    fp.sgn  = smp[IN_W-1];
    fp.ex   = EXP_W'(e);
    fp.mt   = norm_mant(mag, e);
  end

endmodule

// File: rtl/est_fmul.sv
module est_fmul
  import adpcm_est_pkg::*;
#(
  parameter int COEF_W    = 16,
  parameter int COEF_FRAC = 14,
  parameter int COEF_DROP = 2,
  parameter int RND_SH    = 4,
  parameter int OUT_W     = 16,
  parameter int OUT_FRAC  = 1
) (
  input  logic signed [COEF_W-1:0] coef,
  input  fp_t                      smp,
  output logic signed [OUT_W-1:0]  prod
);

  localparam int CMAG_W   = COEF_W - 1 - COEF_DROP;
  localparam int BIAS     = 2 * MANT_W - RND_SH + (COEF_FRAC - COEF_DROP) - OUT_FRAC;
  localparam int RND      = 3 << RND_SH;
  localparam int OUT_MASK = (1 << (OUT_W - 1)) - 1;

  logic [COEF_W-1:0] c_abs;
  logic [CMAG_W-1:0] c_mag;
  logic [MANT_W-1:0] c_mt;
  int unsigned       c_e;
  int unsigned       e_sum;
  logic [31:0]       w;
  logic [31:0]       mag;

  always_comb begin
    c_abs = coef[COEF_W-1] ? COEF_W'(-coef) : COEF_W'(coef);
    c_mag = CMAG_W'(c_abs >> COEF_DROP);
    c_e   = lead_exp(32'(c_mag));
    c_mt  = norm_mant(32'(c_mag), c_e);
    e_sum = c_e + 32'(smp.ex);
    w     = ((32'(c_mt) * 32'(smp.mt)) + 32'(RND)) >> RND_SH;
    if (e_sum > 32'(BIAS)) mag = (w << (e_sum - 32'(BIAS))) & 32'(OUT_MASK);
    else                   mag = w >> (32'(BIAS) - e_sum);
    prod  = (coef[COEF_W-1] ^ smp.sgn) ? -OUT_W'(mag) : OUT_W'(mag);
  end

endmodule

// File: rtl/est_delay.sv
module est_delay
  import adpcm_est_pkg::*;
#(
  parameter int DEPTH = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  push,
  input  fp_t                   din,
  output fp_t [DEPTH-1:0]       taps
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      taps <= {DEPTH{FP_ZERO}};
    end else if (push) begin
      taps[0] <= din;
      for (int i = 1; i < DEPTH; i++) taps[i] <= taps[i-1];
    end
  end

  // R8: newest entry takes the pushed sample
  a_r8_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> (taps[0] == $past(din)));

  // R8: without a push the history is untouched
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !push |=> $stable(taps));

endmodule

// File: rtl/adpcm_sig_est.sv
module adpcm_sig_est
  import adpcm_est_pkg::*;
#(
  parameter int N_ZERO = 6,
  parameter int N_POLE = 2,
  parameter int SMP_W  = 16,
  parameter int COEF_W = 16,
  parameter int OUT_W  = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start_valid,
  output logic                       start_ready,
  input  logic                       push_valid,
  output logic                       push_ready,
  input  logic signed [SMP_W-1:0]    dq_in,
  input  logic signed [SMP_W-1:0]    sr_in,
  input  logic [N_ZERO*COEF_W-1:0]   coef_b,
  input  logic [N_POLE*COEF_W-1:0]   coef_a,
  output logic signed [OUT_W-1:0]    sez_out,
  output logic                       sez_valid,
  output logic signed [OUT_W-1:0]    se_out,
  output logic                       se_valid
);

  localparam int N_TAPS = N_ZERO + N_POLE;
  localparam int IDX_W  = $clog2(N_TAPS);

  logic                     busy;
  logic [IDX_W-1:0]         idx;
  logic signed [OUT_W-1:0]  acc;
  logic signed [OUT_W-1:0]  prod;
  logic signed [OUT_W-1:0]  sum_now;
  logic                     start_go;
  logic                     push_go;
  fp_t                      fp_dq;
  fp_t                      fp_sr;
  fp_t [N_ZERO-1:0]         dq_taps;
  fp_t [N_POLE-1:0]         sr_taps;
  fp_t [N_TAPS-1:0]         all_smp;
  logic [N_TAPS-1:0][COEF_W-1:0] all_coef;

  assign start_ready = !busy;
  assign push_ready  = !busy && !start_valid;
  assign start_go    = start_valid && start_ready;
  assign push_go     = push_valid && push_ready;

  est_fconv #(.IN_W(SMP_W)) u_cv_dq (.smp(dq_in), .fp(fp_dq));
  est_fconv #(.IN_W(SMP_W)) u_cv_sr (.smp(sr_in), .fp(fp_sr));

  est_delay #(.DEPTH(N_ZERO)) u_hist_dq (
    .clk(clk), .rst_n(rst_n), .push(push_go), .din(fp_dq), .taps(dq_taps));
  est_delay #(.DEPTH(N_POLE)) u_hist_sr (
    .clk(clk), .rst_n(rst_n), .push(push_go), .din(fp_sr), .taps(sr_taps));

  // product order: zero taps first, then pole taps
  for (genvar g = 0; g < N_ZERO; g++) begin : g_zero
    assign all_smp[g]  = dq_taps[g];
    assign all_coef[g] = coef_b[g*COEF_W +: COEF_W];
  end
  for (genvar g = 0; g < N_POLE; g++) begin : g_pole
    assign all_smp[N_ZERO+g]  = sr_taps[g];
    assign all_coef[N_ZERO+g] = coef_a[g*COEF_W +: COEF_W];
  end

  est_fmul #(.COEF_W(COEF_W), .OUT_W(OUT_W)) u_mul (
    .coef(all_coef[idx]), .smp(all_smp[idx]), .prod(prod));

  assign sum_now = acc + prod;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      idx       <= '0;
      acc       <= '0;
      sez_out   <= '0;
      se_out    <= '0;
      sez_valid <= 1'b0;
      se_valid  <= 1'b0;
    end else begin
      sez_valid <= 1'b0;
      se_valid  <= 1'b0;
      if (start_go) begin
        busy <= 1'b1;
        idx  <= '0;
        acc  <= '0;
      end else if (busy) begin
        acc <= sum_now;
        idx <= idx + 1'b1;
        if (idx == IDX_W'(N_ZERO - 1)) begin
          sez_out   <= sum_now >>> 1;
          sez_valid <= 1'b1;
        end
        if (idx == IDX_W'(N_TAPS - 1)) begin
          se_out   <= sum_now >>> 1;
          se_valid <= 1'b1;
          busy     <= 1'b0;
        end
      end
    end
  end

  // R6: each strobe lasts one cycle
  a_r6_sez_single: assert property (@(posedge clk) disable iff (!rst_n)
    sez_valid |=> !sez_valid);

  // R6: full estimate follows the partial one by two cycles
  a_r6_se_after_sez: assert property (@(posedge clk) disable iff (!rst_n)
    se_valid |-> $past(sez_valid, 2));

  // R7: no start accepted while the partial result is being reported
  a_r7_busy_at_sez: assert property (@(posedge clk) disable iff (!rst_n)
    sez_valid |-> !start_ready);

  // R6: block is idle again once the full estimate appears
  a_r6_se_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    se_valid |-> start_ready);

  // R9: outputs move only with their strobes
  a_r9_sez_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sez_out) |-> sez_valid);
  a_r9_se_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(se_out) |-> se_valid);

endmodule

// File: tb/test_adpcm_sig_est.sv
module test_adpcm_sig_est;

  localparam int CLK_NS = 10;
  localparam int NZ = 6;
  localparam int NP = 2;

  logic               clk;
  logic               rst_n;
  logic               start_valid;
  logic               start_ready;
  logic               push_valid;
  logic               push_ready;
  logic signed [15:0] dq_in;
  logic signed [15:0] sr_in;
  logic [NZ*16-1:0]   coef_b;
  logic [NP*16-1:0]   coef_a;
  logic signed [15:0] sez_out;
  logic               sez_valid;
  logic signed [15:0] se_out;
  logic               se_valid;

  adpcm_sig_est i_adpcm_sig_est (
    .clk(clk), .rst_n(rst_n),
    .start_valid(start_valid), .start_ready(start_ready),
    .push_valid(push_valid), .push_ready(push_ready),
    .dq_in(dq_in), .sr_in(sr_in), .coef_b(coef_b), .coef_a(coef_a),
    .sez_out(sez_out), .sez_valid(sez_valid),
    .se_out(se_out), .se_valid(se_valid));

  initial clk = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  int n_chk = 0;
  int n_err = 0;

  // stimulus table: pushed samples and coefficient recipe
  localparam int NV = 10;
  localparam int V_DQ[NV] = '{100, -250, 0, 32767, -32768, 1, -1, 4000, -17, 900};
  localparam int V_SR[NV] = '{200, -3000, 5, -32768, 32767, 0, 12000, -9, 64, -640};
  localparam int V_B0[NV] = '{16384, -8192, 3000, 20000, -20000, 500, 12000, -32768, 7000, -1200};
  localparam int V_A1[NV] = '{29000, -24000, 15000, -16384, 16384, 0, 8000, -4000, 32767, -15000};
  localparam int V_A2[NV] = '{-12000, 12000, 0, 8192, -8192, 2000, -6000, 16384, -32768, 3000};

  int h_dq[NZ];
  int h_sr[NP];
  int cb[NZ];
  int ca[NP];

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int m_float(input int x);
    int s, m, e, t, mt;
    s = (x < 0) ? 1 : 0;
    m = (x < 0) ? -x : x;
    if (m > 32767) m = 32767;
    e = 0; t = m;
    while (t != 0) begin e++; t = t >> 1; end
    if (m == 0)     mt = 32;
    else if (e > 6) mt = m >> (e - 6);
    else            mt = m << (6 - e);
    return (s << 10) | (e << 6) | mt;
  endfunction

  function automatic int m_prod(input int c, input int f);
    int cs, cm, cf, ce, cmt, fs, fe, fm, es, w, mg;
    cs  = (c < 0) ? 1 : 0;
    cm  = cs ? ((((-c) & 65535) >> 2) & 8191) : (c >> 2);
    cf  = m_float(cm);
    ce  = (cf >> 6) & 15;
    cmt = cf & 63;
    fs  = (f >> 10) & 1;
    fe  = (f >> 6) & 15;
    fm  = f & 63;
    es  = ce + fe;
    w   = (cmt * fm + 48) >> 4;
    if (es > 19) mg = (w << (es - 19)) & 32767;
    else         mg = w >> (19 - es);
    return (cs != fs) ? -mg : mg;
  endfunction

  function automatic int half16(input int sum);
    logic signed [15:0] s;
    s = 16'(sum);
    return int'(s >>> 1);
  endfunction

  function automatic int exp_sez();
    int sum = 0;
    for (int j = 0; j < NZ; j++) sum += m_prod(cb[j], m_float(h_dq[j]));
    return half16(sum);
  endfunction

  function automatic int exp_se();
    int sum = 0;
    for (int j = 0; j < NZ; j++) sum += m_prod(cb[j], m_float(h_dq[j]));
    for (int j = 0; j < NP; j++) sum += m_prod(ca[j], m_float(h_sr[j]));
    return half16(sum);
  endfunction

  task automatic drive_coefs();
    for (int j = 0; j < NZ; j++) coef_b[j*16 +: 16] = 16'(cb[j]);
    for (int j = 0; j < NP; j++) coef_a[j*16 +: 16] = 16'(ca[j]);
  endtask

  task automatic set_all(input int v);
    for (int j = 0; j < NZ; j++) cb[j] = v;
    for (int j = 0; j < NP; j++) ca[j] = v;
    drive_coefs();
  endtask

  task automatic model_clear();
    for (int j = 0; j < NZ; j++) h_dq[j] = 0;
    for (int j = 0; j < NP; j++) h_sr[j] = 0;
  endtask

  task automatic push(input int dq, input int sr);
    @(negedge clk);
    dq_in = 16'(dq); sr_in = 16'(sr); push_valid = 1'b1;
    @(negedge clk);
    push_valid = 1'b0;
    for (int j = NZ - 1; j > 0; j--) h_dq[j] = h_dq[j-1];
    for (int j = NP - 1; j > 0; j--) h_sr[j] = h_sr[j-1];
    h_dq[0] = int'($signed(16'(dq)));
    h_sr[0] = int'($signed(16'(sr)));
  endtask

  task automatic run(output int g_sez, output int g_se, output int c_sez, output int c_se);
    g_sez = 0; g_se = 0; c_sez = -1; c_se = -1;
    @(negedge clk);
    start_valid = 1'b1;
    @(negedge clk);
    start_valid = 1'b0;
    for (int c = 1; c <= 20; c++) begin
      @(negedge clk);
      if (sez_valid) begin g_sez = int'(sez_out); c_sez = c; end
      if (se_valid) begin g_se = int'(se_out); c_se = c; break; end
    end
  endtask

  initial begin
    #(CLK_NS * 100000);
    n_chk++; n_err++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    int gs, ge, cs, ce, extra;
    rst_n = 1'b0; start_valid = 1'b0; push_valid = 1'b0;
    dq_in = '0; sr_in = '0; coef_b = '0; coef_a = '0;
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: idle state after reset
    chk("R1 sez_out", int'(sez_out), 0);
    chk("R1 se_out", int'(se_out), 0);
    chk("R1 strobes", int'(sez_valid) + int'(se_valid), 0);
    chk("R1 ready", int'(start_ready) + int'(push_ready), 2);

    // R1 R3: zero history with unit coefficients
    set_all(16384);
    run(gs, ge, cs, ce);
    chk("R1 sez unit", gs, 3);
    chk("R1 se unit", ge, 4);
    chk("R6 sez cycle", cs, 6);
    chk("R6 se cycle", ce, 8);

    // R4 R5: negative sums use arithmetic shift
    set_all(-16384);
    run(gs, ge, cs, ce);
    chk("R4 sez negative", gs, -3);
    chk("R5 se negative", ge, -4);

    // R2 R3: hand-computed single-tap case
    set_all(0);
    cb[0] = 16384; ca[0] = 16384; drive_coefs();
    push(100, 100);
    run(gs, ge, cs, ce);
    chk("R3 sez hand", gs, 103);
    chk("R5 se hand", ge, 206);

    // R9: results hold between strobes
    repeat (5) @(negedge clk);
    chk("R9 sez hold", int'(sez_out), 103);
    chk("R9 se hold", int'(se_out), 206);

    // R2 R4 R5 R8: table walk, history shifts and drops oldest
    for (int v = 0; v < NV; v++) begin
      for (int j = 0; j < NZ; j++) cb[j] = int'($signed(16'(V_B0[v] - j * 1500)));
      ca[0] = int'($signed(16'(V_A1[v])));
      ca[1] = int'($signed(16'(V_A2[v])));
      drive_coefs();
      push(V_DQ[v], V_SR[v]);
      run(gs, ge, cs, ce);
      chk($sformatf("R4 sez vec %0d", v), gs, exp_sez());
      chk($sformatf("R5 se vec %0d", v), ge, exp_se());
    end

    // R7 R8: start and push offered while busy are ignored
    @(negedge clk);
    start_valid = 1'b1;
    @(negedge clk);
    start_valid = 1'b0;
    repeat (2) @(negedge clk);
    chk("R7 start_ready busy", int'(start_ready), 0);
    chk("R8 push_ready busy", int'(push_ready), 0);
    start_valid = 1'b1; push_valid = 1'b1; dq_in = 16'sd5000; sr_in = 16'sd5000;
    @(negedge clk);
    start_valid = 1'b0; push_valid = 1'b0;
    gs = 0;
    for (int c = 0; c < 20; c++) begin
      if (se_valid) break;
      @(negedge clk);
    end
    extra = 0;
    for (int c = 0; c < 12; c++) begin
      @(negedge clk);
      extra += int'(sez_valid) + int'(se_valid);
    end
    chk("R7 no extra strobe", extra, 0);
    run(gs, ge, cs, ce);
    chk("R8 busy push ignored", ge, exp_se());

    // R8: start wins over a push in the same cycle
    @(negedge clk);
    start_valid = 1'b1; push_valid = 1'b1; dq_in = 16'sd7777; sr_in = -16'sd7777;
    #1;
    chk("R8 push_ready with start", int'(push_ready), 0);
    @(negedge clk);
    start_valid = 1'b0; push_valid = 1'b0;
    ge = 0;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      if (se_valid) begin ge = int'(se_out); break; end
    end
    chk("R8 start priority", ge, exp_se());

    // R2: magnitude limit on the most negative sample
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    model_clear();
    set_all(0);
    cb[0] = 16384; drive_coefs();
    push(-32768, 0);
    run(gs, ge, cs, ce);
    chk("R2 saturated sez", gs, -256);
    chk("R2 saturated se", ge, -256);

    // R1: reset in the middle of a computation
    @(negedge clk);
    start_valid = 1'b1;
    @(negedge clk);
    start_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    model_clear();
    @(negedge clk);
    chk("R1 mid reset outputs", int'(sez_out) + int'(se_out), 0);
    chk("R1 mid reset ready", int'(start_ready), 1);
    set_all(16384);
    run(gs, ge, cs, ce);
    chk("R1 history cleared sez", gs, 3);
    chk("R1 history cleared se", ge, 4);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule